// File: doc/BRIEF.md
# Warp Divergence Mask Sequencer

This block keeps the lane-enable mask and the program counter of one 32-lane warp that issues a single instruction stream in lockstep. When a branch is issued, each lane supplies a predicate bit. If the active lanes all agree, the warp simply jumps or falls through. If they disagree, the warp cannot follow both paths at once. The block narrows the mask to the lanes whose predicate is set and starts them on the branch target. It records the other lanes, their start address and the join address in a small last-in first-out stack.

When the running path reaches the join address, the block stalls issue for one cycle. It then switches to the deferred lanes at their start address. When those lanes also reach the join address, it stalls one more cycle and restores the full mask that existed before the branch. Since both paths run one after the other, a split branch costs the time of both paths. A counter records every cycle in which only part of the warp is enabled, so that this serialization cost can be measured. The mask and the program counter drive the lane array directly.

Top module: `warp_mask_seq`

## Requirements
- R1: On synchronous active-low reset the mask is all ones, the program counter is RESET_PC, the serialization counter is zero, and `join_stall`, `stack_full` and `overflow` are low.
- R2: With `issue` high, `br_valid` low and `join_stall` low, the program counter advances by one on the next cycle and the mask is unchanged.
- R3: A branch is divergent when, among the enabled lanes, some have the predicate bit set and some have it clear (bit i of `br_pred` and of `lane_mask` belongs to lane i). On such a branch, with the stack not full, the next mask is the enabled lanes with the predicate set, the next program counter is `br_target`, and one stack entry is pushed. For example, a predicate of 0x0000000F on a full warp leaves lanes 0 to 3 enabled.
- R4: A uniform branch pushes nothing and keeps the mask. If every enabled lane has the predicate set, the next program counter is `br_target`. If none has it set, the next program counter is `br_fallthru`.
- R5: While the stack holds an entry whose join address equals the program counter, and that entry's deferred path has not yet run, `join_stall` is high for one cycle and `issue` and the branch inputs are ignored. On the next cycle the mask is the deferred lanes and the program counter is the deferred start address.
- R6: When the deferred path reaches the join address, `join_stall` is high for one cycle and the inputs are ignored. On the next cycle the mask is the mask that existed before the branch, the program counter stays at the join address, and the entry is removed.
- R7: `stack_full` is high exactly while DEPTH entries are held.
- R8: A divergent branch that arrives while the stack is full pushes nothing and leaves the mask unchanged. It moves the program counter to `br_fallthru` and sets `overflow`, which stays high until reset.
- R9: `serial_cycles` increases by one after every cycle in which the mask is neither all ones nor all zeros, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | A non-branch instruction was issued at the current PC |
| br_valid | input | 1 | A branch was issued at the current PC |
| br_pred | input | LANES | Per-lane branch predicate, bit i for lane i |
| br_target | input | PC_W | Start address of the predicate-true path |
| br_fallthru | input | PC_W | Start address of the predicate-false path |
| br_join | input | PC_W | Address where both paths meet again |
| lane_mask | output | LANES | Lanes enabled for the current instruction |
| cur_pc | output | PC_W | Program counter of the warp |
| join_stall | output | 1 | Rejoin cycle; the lane array must not issue |
| stack_full | output | 1 | Deferral stack holds DEPTH entries |
| overflow | output | 1 | Sticky: a split was refused because the stack was full |
| serial_cycles | output | CNT_W | Count of cycles run with a partial mask |

## Verification
The properties assume that `issue` and `br_valid` are never high together, and that no instruction is offered while `join_stall` is high. They also assume that the join address of a split is never reached in a way that skips a cycle of the stall. The stimulus follows these rules except in one deliberate case: it drives a branch and an issue during a stall to show that they are ignored. That cycle falls under the rejoin property, which expects a mask change whatever the inputs do. The stimulus also offers branches only at addresses that differ from the pending join address, so each stall is caused by reaching the join and not by a branch that lands on it.

// File: rtl/warp_mask_pkg.sv
// Package: shared branch classification for the warp mask sequencer.
// Assumes: used by warp_mask_split and warp_mask_seq only.
package warp_mask_pkg;
    typedef enum logic [1:0] {
        BR_ALL_TAKEN  = 2'd0,
        BR_NONE_TAKEN = 2'd1,
        BR_SPLIT      = 2'd2
    } br_kind_e;
endpackage

// File: rtl/warp_mask_split.sv
// Module: warp_mask_split
// Splits the enabled lanes by predicate and classifies the branch.
// Assumes: enabled mask is never all zeros while a branch is offered.
module warp_mask_split
    import warp_mask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] act_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] taken_o,
    output logic [LANES-1:0] other_o,
    output br_kind_e         kind_o
);
    // Partition the enabled lanes and decide whether they disagree.
    always_comb begin
        taken_o = act_i & pred_i;
        other_o = act_i & ~pred_i;
        if (other_o == '0)      kind_o = BR_ALL_TAKEN;
        else if (taken_o == '0) kind_o = BR_NONE_TAKEN;
        else                    kind_o = BR_SPLIT;
    end
endmodule

// File: rtl/warp_mask_stack.sv
// Module: warp_mask_stack
// LIFO of deferred paths. Each entry holds the mask before the split, the
// deferred lanes, the deferred start address, the join address and a flag
// marking that the deferred path is running.
// Assumes: push only when not full, pop/mark only when not empty, DEPTH >= 2.
module warp_mask_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             mark_i,
    input  logic [LANES-1:0] push_orig_i,
    input  logic [LANES-1:0] push_def_i,
    input  logic [PC_W-1:0]  push_pc_i,
    input  logic [PC_W-1:0]  push_join_i,
    output logic [LANES-1:0] top_orig_o,
    output logic [LANES-1:0] top_def_o,
    output logic [PC_W-1:0]  top_pc_o,
    output logic [PC_W-1:0]  top_join_o,
    output logic             top_second_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LANES-1:0] orig;
        logic [LANES-1:0] dmask;
        logic [PC_W-1:0]  dpc;
        logic [PC_W-1:0]  jpc;
        logic             second;
    } entry_t;

    entry_t           mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_cnt;
    logic [IDX_W-1:0] top_idx;
    entry_t           top_e;

    // Select the newest entry.
    always_comb begin
        top_cnt = cnt_q - CNT_W'(1);
        top_idx = top_cnt[IDX_W-1:0];
        top_e   = mem_q[top_idx];
    end

    assign top_orig_o   = top_e.orig;
    assign top_def_o    = top_e.dmask;
    assign top_pc_o     = top_e.dpc;
    assign top_join_o   = top_e.jpc;
    assign top_second_o = top_e.second;
    assign empty_o      = (cnt_q == '0);
    assign full_o       = (cnt_q == CNT_W'(DEPTH));

    // Track the number of held entries.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (push_i) cnt_q <= cnt_q + CNT_W'(1);
        else if (pop_i)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // Write a new entry or flag the top entry as in its second phase.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else if (push_i && cnt_q == CNT_W'(g)) begin
                    mem_q[g] <= '{orig: push_orig_i, dmask: push_def_i,
                                  dpc: push_pc_i, jpc: push_join_i, second: 1'b0};
                end else if (mark_i && cnt_q == CNT_W'(g + 1)) begin
                    mem_q[g].second <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/warp_mask_count.sv
// Module: warp_mask_count
// Counts cycles in which only part of the warp is enabled.
// Assumes: wraps at 2**CNT_W.
module warp_mask_count #(
    parameter int LANES = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_i,
    output logic [CNT_W-1:0] count_o
);
    logic partial;
    assign partial = (mask_i != '0) && (mask_i != '1);

    // Advance once per partial-mask cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (partial) count_o <= count_o + CNT_W'(1);
    end
endmodule

// File: rtl/warp_mask_seq.sv
// Module: warp_mask_seq (top)
// Keeps the enabled-lane mask and PC of one warp, serializes divergent
// branches through a deferral stack and counts serialized cycles.
// Assumes: issue and br_valid are exclusive; nothing issues on join_stall.
module warp_mask_seq
    import warp_mask_pkg::*;
#(
    parameter int          LANES    = 32,
    parameter int          PC_W     = 16,
    parameter int          DEPTH    = 8,
    parameter int          CNT_W    = 32,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_pred,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_join,
    output logic [LANES-1:0] lane_mask,
    output logic [PC_W-1:0]  cur_pc,
    output logic             join_stall,
    output logic             stack_full,
    output logic             overflow,
    output logic [CNT_W-1:0] serial_cycles
);
    logic [LANES-1:0] mask_q, mask_d;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic             ovf_q, ovf_set;
    logic [LANES-1:0] taken, other;
    br_kind_e         kind;
    logic             push, pop, mark, empty;
    logic [LANES-1:0] top_orig, top_def;
    logic [PC_W-1:0]  top_pc, top_join;
    logic             top_second;

    warp_mask_split #(.LANES(LANES)) split_i (
        .act_i(mask_q), .pred_i(br_pred),
        .taken_o(taken), .other_o(other), .kind_o(kind)
    );

    warp_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) stack_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .pop_i(pop), .mark_i(mark),
        .push_orig_i(mask_q), .push_def_i(other),
        .push_pc_i(br_fallthru), .push_join_i(br_join),
        .top_orig_o(top_orig), .top_def_o(top_def),
        .top_pc_o(top_pc), .top_join_o(top_join), .top_second_o(top_second),
        .empty_o(empty), .full_o(stack_full)
    );

    warp_mask_count #(.LANES(LANES), .CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .mask_i(mask_q), .count_o(serial_cycles)
    );

    assign join_stall = !empty && (pc_q == top_join);

    // Choose the next mask and PC: rejoin first, then branch, then step.
    always_comb begin
        mask_d  = mask_q;
        pc_d    = pc_q;
        push    = 1'b0;
        pop     = 1'b0;
        mark    = 1'b0;
        ovf_set = 1'b0;
        if (join_stall) begin
            if (!top_second) begin
                mask_d = top_def;
                pc_d   = top_pc;
                mark   = 1'b1;
            end else begin
                mask_d = top_orig;
                pop    = 1'b1;
            end
        end else if (br_valid) begin
            unique case (kind)
                BR_ALL_TAKEN:  pc_d = br_target;
                BR_NONE_TAKEN: pc_d = br_fallthru;
                default: begin
                    if (stack_full) begin
                        ovf_set = 1'b1;
                        pc_d    = br_fallthru;
                    end else begin
                        push   = 1'b1;
                        mask_d = taken;
                        pc_d   = br_target;
                    end
                end
            endcase
        end else if (issue) begin
            pc_d = pc_q + PC_W'(1);
        end
    end

    // Hold warp state and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pc_q   <= RESET_PC[PC_W-1:0];
            ovf_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            pc_q   <= pc_d;
            ovf_q  <= ovf_q | ovf_set;
        end
    end

    assign lane_mask = mask_q;
    assign cur_pc    = pc_q;
    assign overflow  = ovf_q;
endmodule

// File: rtl/warp_mask_seq_chk.sv
// Module: warp_mask_seq_chk
// Temporal checks on the ports of warp_mask_seq, attached by bind.
// Assumes: issue and br_valid exclusive; no offer during join_stall.
module warp_mask_seq_chk #(
    parameter int          LANES    = 32,
    parameter int          PC_W     = 16,
    parameter int          CNT_W    = 32,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic             br_valid,
    input logic [LANES-1:0] br_pred,
    input logic [PC_W-1:0]  br_target,
    input logic [LANES-1:0] lane_mask,
    input logic [PC_W-1:0]  cur_pc,
    input logic             join_stall,
    input logic             overflow,
    input logic [CNT_W-1:0] serial_cycles
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (lane_mask == '1 && cur_pc == RESET_PC[PC_W-1:0]
                    && serial_cycles == '0 && !overflow));

    // R2
    step_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !br_valid && !join_stall)
        |=> (cur_pc == $past(cur_pc) + PC_W'(1) && $stable(lane_mask)));

    // R3
    split_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !join_stall && !overflow && ((lane_mask & br_pred) != '0)
         && ((lane_mask & ~br_pred) != '0))
        |=> (((lane_mask == $past(lane_mask & br_pred)) && cur_pc == $past(br_target))
             || overflow));

    // R3
    lanes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mask != '0);

    // R4
    uniform_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !join_stall && ((lane_mask & ~br_pred) == '0))
        |=> ($stable(lane_mask) && cur_pc == $past(br_target)));

    // R5
    rejoin_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_stall |=> (lane_mask != $past(lane_mask)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9
    serial_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask != '0 && lane_mask != '1)
        |=> (serial_cycles == $past(serial_cycles) + CNT_W'(1)));
endmodule

bind warp_mask_seq warp_mask_seq_chk #(
    .LANES(LANES), .PC_W(PC_W), .CNT_W(CNT_W), .RESET_PC(RESET_PC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .br_valid(br_valid),
    .br_pred(br_pred), .br_target(br_target), .lane_mask(lane_mask),
    .cur_pc(cur_pc), .join_stall(join_stall), .overflow(overflow),
    .serial_cycles(serial_cycles)
);

// File: tb/warp_mask_seq_tb_top.sv
// Bench: scoreboard for warp_mask_seq. The driver pushes expected state per
// cycle; the monitor pops and compares just after each rising edge.
module warp_mask_seq_tb_top;
    localparam int LANES = 32;
    localparam int PC_W  = 16;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_pred = '0;
    logic [PC_W-1:0]  br_target = '0;
    logic [PC_W-1:0]  br_fallthru = '0;
    logic [PC_W-1:0]  br_join = '0;
    logic [LANES-1:0] lane_mask;
    logic [PC_W-1:0]  cur_pc;
    logic             join_stall;
    logic             stack_full;
    logic             overflow;
    logic [CNT_W-1:0] serial_cycles;

    typedef struct {
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  pc;
        logic             stall;
        logic             full;
        logic             ovf;
        string            req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   exp_cnt = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    warp_mask_seq dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .br_valid(br_valid),
        .br_pred(br_pred), .br_target(br_target), .br_fallthru(br_fallthru),
        .br_join(br_join), .lane_mask(lane_mask), .cur_pc(cur_pc),
        .join_stall(join_stall), .stack_full(stack_full), .overflow(overflow),
        .serial_cycles(serial_cycles)
    );

    task automatic check(input bit ok, input string req, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // Drive one cycle of stimulus and queue the state expected after it.
    task automatic drive(input bit iss, input bit br, input logic [LANES-1:0] pred,
                         input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] nt,
                         input logic [PC_W-1:0] jn, input logic [LANES-1:0] emask,
                         input logic [PC_W-1:0] epc, input bit estall, input bit efull,
                         input bit eovf, input string req);
        exp_t e;
        @(negedge clk);
        issue = iss; br_valid = br; br_pred = pred;
        br_target = tgt; br_fallthru = nt; br_join = jn;
        e.mask = emask; e.pc = epc; e.stall = estall;
        e.full = efull; e.ovf = eovf; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        issue = 1'b0; br_valid = 1'b0; br_pred = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; issue = 1'b0; br_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    // Monitor: compare state and the serialization count after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(lane_mask == e.mask && cur_pc == e.pc && join_stall == e.stall
                  && stack_full == e.full && overflow == e.ovf, e.req,
                  $sformatf("mask=%h pc=%h stall=%0b full=%0b ovf=%0b exp mask=%h pc=%h stall=%0b full=%0b ovf=%0b",
                            lane_mask, cur_pc, join_stall, stack_full, overflow,
                            e.mask, e.pc, e.stall, e.full, e.ovf));
            // R9: count reflects partial masks seen before this edge
            check(serial_cycles == CNT_W'(exp_cnt), "R9",
                  $sformatf("serial_cycles=%0d exp=%0d", serial_cycles, exp_cnt));
            if (e.mask != '0 && e.mask != '1) exp_cnt++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, exp=done");
        finish_run();
    end

    initial begin
        logic [LANES-1:0] m;
        do_reset();
        #1;
        // R1: reset state
        check(lane_mask == '1 && cur_pc == '0 && serial_cycles == '0, "R1",
              $sformatf("mask=%h pc=%h cnt=%0d exp ffffffff/0000/0", lane_mask, cur_pc, serial_cycles));
        check(!join_stall && !stack_full && !overflow, "R1",
              $sformatf("stall=%0b full=%0b ovf=%0b exp 0/0/0", join_stall, stack_full, overflow));

        // Split lanes 0-3 from the rest, run both paths and rejoin.
        drive(1, 0, '0, 0, 0, 0, 32'hFFFF_FFFF, 16'h0001, 0, 0, 0, "R2");
        drive(0, 1, 32'h0000_000F, 16'h0010, 16'h0002, 16'h0020,
              32'h0000_000F, 16'h0010, 0, 0, 0, "R3");
        drive(0, 1, 32'hFFFF_FFFF, 16'h001E, 16'h0005, 16'h0030,
              32'h0000_000F, 16'h001E, 0, 0, 0, "R4");
        drive(1, 0, '0, 0, 0, 0, 32'h0000_000F, 16'h001F, 0, 0, 0, "R2");
        drive(1, 0, '0, 0, 0, 0, 32'h0000_000F, 16'h0020, 1, 0, 0, "R5");
        // R5: branch and issue offered during the stall are ignored
        drive(1, 1, 32'h0000_0000, 16'h0077, 16'h0077, 16'h0077,
              32'hFFFF_FFF0, 16'h0002, 0, 0, 0, "R5");
        // R4: predicate set only on disabled lanes -> fall through
        drive(0, 1, 32'h0000_000F, 16'h0050, 16'h001F, 16'h0060,
              32'hFFFF_FFF0, 16'h001F, 0, 0, 0, "R4");
        drive(1, 0, '0, 0, 0, 0, 32'hFFFF_FFF0, 16'h0020, 1, 0, 0, "R6");
        drive(1, 0, '0, 0, 0, 0, 32'hFFFF_FFFF, 16'h0020, 0, 0, 0, "R6");
        drive(1, 0, '0, 0, 0, 0, 32'hFFFF_FFFF, 16'h0021, 0, 0, 0, "R2");
        idle();
        repeat (2) @(negedge clk);

        // Fill the stack with nested splits, then overflow it.
        do_reset();
        m = '1;
        for (int k = 0; k < 8; k++) begin
            m = m & ~(LANES'(1) << k);
            drive(0, 1, m, PC_W'(16'h0040 + k), PC_W'(16'h0080 + k), PC_W'(16'h0100 + k),
                  m, PC_W'(16'h0040 + k), 0, (k == 7), 0, (k == 7) ? "R7" : "R3");
        end
        drive(0, 1, m & ~(LANES'(1) << 8), 16'h0050, 16'h0088, 16'h0200,
              m, 16'h0088, 0, 1, 1, "R8");
        drive(1, 0, '0, 0, 0, 0, m, 16'h0089, 0, 1, 1, "R8");
        idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule